// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a chip between four power modes: Active, Doze, Deep-sleep and Power-down. For each mode it drives the main-clock enable, the radio/analog domain switch, the linear-regulator enable, the digital-core power switch, the core isolation control and the master regulator enable. A one-cycle request strobe carrying a target mode starts a transition, and only while the controller is Active. The controller returns to Active either on a wake event or, from Power-down, on an external enable.

Deep-sleep is the only mode with handshaked sequences. On entry the clocks are gated, core state is saved into always-on retention storage (save strobe, then wait for save-done), the core is isolated and its power removed. On exit the core is powered, a programmable settle time elapses, state is restored (restore strobe, then wait for restore-done), isolation is released and the clocks come back. A wake event that arrives during entry is remembered. The entry is cancelled once the step in progress finishes.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is Active: mainClkEn, analogPwrEn, linRegEn, corePwrEn and regEn are 1, coreIsoEn, saveStrobe and restoreStrobe are 0, and modeStatus is 0.
- R2: A request with reqMode 1 in Active enters Doze one cycle later. Clock, analog and linear-regulator enables are then 0, core power and regEn stay 1, isolation is 0, and modeStatus is 1.
- R3: In Doze, a one-cycle pulse on any one of wakeTimer, wakeIrq or wakeHost returns the controller to Active, with all Active outputs and modeStatus 0, one cycle later.
- R4: A request with reqMode 2 in Active sets modeStatus to 2 and gates the clock one cycle later. It then issues a single-cycle saveStrobe while the clock is gated. coreIsoEn stays 0 until saveDone is seen, and corePwrEn drops only after coreIsoEn is 1.
- R5: When Deep-sleep is reached, only regEn and coreIsoEn are 1. A wake pulse from any source turns corePwrEn on one cycle later. A single-cycle restoreStrobe follows exactly settleCount+1 cycles after corePwrEn rises.
- R6: On Deep-sleep exit, coreIsoEn stays 1 until restoreDone is seen. The clocks are ungated one cycle after isolation is released, and the controller is then Active with modeStatus 0.
- R7: A wake pulse during Deep-sleep entry returns the controller to Active once the step in progress completes: at once after clock gating, on saveDone while the save is pending, or from the isolated state. Core power is never removed during an aborted entry.
- R8: A request with reqMode 3 in Active turns every enable output off and sets modeStatus to 3. Wake pulses have no effect there, and only extEnable returns the controller to Active.
- R9: A request is ignored when its mode is 0, or when the controller is not in Active. Outputs and modeStatus keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle mode request strobe |
| reqMode | input | 2 | Requested mode: 0 Active, 1 Doze, 2 Deep-sleep, 3 Power-down |
| wakeTimer | input | 1 | Wake-timer expiry event |
| wakeIrq | input | 1 | External interrupt wake event |
| wakeHost | input | 1 | Host-resume wake event |
| extEnable | input | 1 | External re-enable, leaves Power-down |
| saveDone | input | 1 | Retention save complete |
| restoreDone | input | 1 | Retention restore complete |
| settleCount | input | SETTLE_W | Cycles to wait after core power-on before restore |
| mainClkEn | output | 1 | Main clock enable (0 = gated) |
| analogPwrEn | output | 1 | Radio and analog domain power switch |
| linRegEn | output | 1 | Linear regulator enable |
| corePwrEn | output | 1 | Digital-core power switch |
| coreIsoEn | output | 1 | Core output isolation |
| regEn | output | 1 | Master internal regulator enable |
| saveStrobe | output | 1 | One-cycle start of retention save |
| restoreStrobe | output | 1 | One-cycle start of retention restore |
| modeStatus | output | 2 | Current mode code, 2 throughout Deep-sleep sequences |

## Verification
The hardest situations to reach are the aborted Deep-sleep entries, because the wake must land inside a particular step of the handshake. The bench holds saveDone back so that the controller parks in the wait-for-save step, or releases it exactly once so that the controller parks in the isolated step. It then injects a wake pulse from each source in turn. The exit settle window is swept over several settleCount values, and the distance from core power-on to the restore strobe is measured against settleCount+1.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_DOZE   = 2'd1,
    MODE_DEEP   = 2'd2,
    MODE_OFF    = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    S_ACTIVE,
    S_DOZE,
    S_EN_SAVE,
    S_EN_WAIT,
    S_EN_ISO,
    S_DEEP,
    S_EX_SETTLE,
    S_EX_WAIT,
    S_EX_UNISO,
    S_OFF
  } state_e;

  // Strobes from control to datapath, each valid for one cycle.
  typedef struct packed {
    logic clkOff;
    logic clkOn;
    logic anaOff;
    logic anaOn;
    logic linOff;
    logic linOn;
    logic coreOff;
    logic coreOn;
    logic isoOn;
    logic isoOff;
    logic regOff;
    logic regOn;
    logic save;
    logic restore;
    logic loadSettle;
  } ctl_t;

  localparam int NUM_EN = 6;
  localparam int EN_CLK  = 0;
  localparam int EN_ANA  = 1;
  localparam int EN_LIN  = 2;
  localparam int EN_CORE = 3;
  localparam int EN_ISO  = 4;
  localparam int EN_REG  = 5;

endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqMode,
  input  logic       wakeTimer,
  input  logic       wakeIrq,
  input  logic       wakeHost,
  input  logic       extEnable,
  input  logic       saveDone,
  input  logic       restoreDone,
  input  logic       settleDone,
  output ctl_t       ctl,
  output logic [1:0] modeStatus
);

  state_e state, nxt;
  logic   wakeAny;
  logic   wakePend;
  logic   inEntry;
  logic   abortReq;

  assign wakeAny  = wakeTimer | wakeIrq | wakeHost;
  assign inEntry  = (state == S_EN_SAVE) || (state == S_EN_WAIT) || (state == S_EN_ISO);
  assign abortReq = wakeAny | wakePend;

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      S_ACTIVE: begin
        if (reqValid) begin
          case (mode_e'(reqMode))
            MODE_DOZE: begin
              ctl.clkOff = 1'b1; ctl.anaOff = 1'b1; ctl.linOff = 1'b1;
              nxt = S_DOZE;
            end
            MODE_DEEP: begin
              ctl.clkOff = 1'b1; ctl.anaOff = 1'b1; ctl.linOff = 1'b1;
              nxt = S_EN_SAVE;
            end
            MODE_OFF: begin
              ctl.clkOff = 1'b1; ctl.anaOff = 1'b1; ctl.linOff = 1'b1;
              ctl.coreOff = 1'b1; ctl.regOff = 1'b1;
              nxt = S_OFF;
            end
            default: ;
          endcase
        end
      end
      S_DOZE: begin
        if (wakeAny) begin
          ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
          nxt = S_ACTIVE;
        end
      end
      S_EN_SAVE: begin
        if (abortReq) begin
          ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
          nxt = S_ACTIVE;
        end else begin
          ctl.save = 1'b1;
          nxt = S_EN_WAIT;
        end
      end
      S_EN_WAIT: begin
        if (saveDone) begin
          if (abortReq) begin
            ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
            nxt = S_ACTIVE;
          end else begin
            ctl.isoOn = 1'b1;
            nxt = S_EN_ISO;
          end
        end
      end
      S_EN_ISO: begin
        if (abortReq) begin
          ctl.isoOff = 1'b1;
          ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
          nxt = S_ACTIVE;
        end else begin
          ctl.coreOff = 1'b1;
          nxt = S_DEEP;
        end
      end
      S_DEEP: begin
        if (wakeAny) begin
          ctl.coreOn = 1'b1; ctl.loadSettle = 1'b1;
          nxt = S_EX_SETTLE;
        end
      end
      S_EX_SETTLE: begin
        if (settleDone) begin
          ctl.restore = 1'b1;
          nxt = S_EX_WAIT;
        end
      end
      S_EX_WAIT: begin
        if (restoreDone) begin
          ctl.isoOff = 1'b1;
          nxt = S_EX_UNISO;
        end
      end
      S_EX_UNISO: begin
        ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
        nxt = S_ACTIVE;
      end
      S_OFF: begin
        if (extEnable) begin
          ctl.regOn = 1'b1; ctl.coreOn = 1'b1;
          ctl.clkOn = 1'b1; ctl.anaOn = 1'b1; ctl.linOn = 1'b1;
          nxt = S_ACTIVE;
        end
      end
      default: nxt = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_ACTIVE;
      wakePend <= 1'b0;
    end else begin
      state    <= nxt;
      wakePend <= (inEntry && nxt != S_ACTIVE) ? (wakePend | wakeAny) : 1'b0;
    end
  end

  always_comb begin
    unique case (state)
      S_ACTIVE: modeStatus = MODE_ACTIVE;
      S_DOZE:   modeStatus = MODE_DOZE;
      S_OFF:    modeStatus = MODE_OFF;
      default:  modeStatus = MODE_DEEP;
    endcase
  end

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [SETTLE_W-1:0] settleCount,
  output logic                settleDone,
  output logic [NUM_EN-1:0]   enables,
  output logic                saveStrobe,
  output logic                restoreStrobe
);

  localparam logic [NUM_EN-1:0] EN_RESET = ~(NUM_EN'(1) << EN_ISO);

  logic [NUM_EN-1:0]   setV, clrV;
  logic [SETTLE_W-1:0] settleCnt;

  always_comb begin
    setV = '0;
    clrV = '0;
    setV[EN_CLK]  = ctl.clkOn;   clrV[EN_CLK]  = ctl.clkOff;
    setV[EN_ANA]  = ctl.anaOn;   clrV[EN_ANA]  = ctl.anaOff;
    setV[EN_LIN]  = ctl.linOn;   clrV[EN_LIN]  = ctl.linOff;
    setV[EN_CORE] = ctl.coreOn;  clrV[EN_CORE] = ctl.coreOff;
    setV[EN_ISO]  = ctl.isoOn;   clrV[EN_ISO]  = ctl.isoOff;
    setV[EN_REG]  = ctl.regOn;   clrV[EN_REG]  = ctl.regOff;
  end

  for (genvar i = 0; i < NUM_EN; i++) begin : g_en
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        enables[i] <= EN_RESET[i];
      else if (clrV[i]) enables[i] <= 1'b0;
      else if (setV[i]) enables[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt     <= '0;
      saveStrobe    <= 1'b0;
      restoreStrobe <= 1'b0;
    end else begin
      saveStrobe    <= ctl.save;
      restoreStrobe <= ctl.restore;
      if (ctl.loadSettle)       settleCnt <= settleCount;
      else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
    end
  end

  assign settleDone = (settleCnt == '0);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqMode,
  input  logic                wakeTimer,
  input  logic                wakeIrq,
  input  logic                wakeHost,
  input  logic                extEnable,
  input  logic                saveDone,
  input  logic                restoreDone,
  input  logic [SETTLE_W-1:0] settleCount,
  output logic                mainClkEn,
  output logic                analogPwrEn,
  output logic                linRegEn,
  output logic                corePwrEn,
  output logic                coreIsoEn,
  output logic                regEn,
  output logic                saveStrobe,
  output logic                restoreStrobe,
  output logic [1:0]          modeStatus
);

  ctl_t              ctl;
  logic              settleDone;
  logic [NUM_EN-1:0] enables;

  lpm_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .wakeTimer(wakeTimer), .wakeIrq(wakeIrq), .wakeHost(wakeHost),
    .extEnable(extEnable), .saveDone(saveDone), .restoreDone(restoreDone),
    .settleDone(settleDone), .ctl(ctl), .modeStatus(modeStatus)
  );

  lpm_datapath #(.SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .settleCount(settleCount),
    .settleDone(settleDone), .enables(enables),
    .saveStrobe(saveStrobe), .restoreStrobe(restoreStrobe)
  );

  assign mainClkEn   = enables[EN_CLK];
  assign analogPwrEn = enables[EN_ANA];
  assign linRegEn    = enables[EN_LIN];
  assign corePwrEn   = enables[EN_CORE];
  assign coreIsoEn   = enables[EN_ISO];
  assign regEn       = enables[EN_REG];

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wakeTimer,
  input logic       wakeIrq,
  input logic       wakeHost,
  input logic       extEnable,
  input logic       mainClkEn,
  input logic       analogPwrEn,
  input logic       corePwrEn,
  input logic       coreIsoEn,
  input logic       regEn,
  input logic       saveStrobe,
  input logic       restoreStrobe,
  input logic [1:0] modeStatus
);

  a_r2_doze_outputs: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus == 2'd1 |-> !mainClkEn && !analogPwrEn && corePwrEn && regEn);

  a_r3_doze_wake: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'd1 && (wakeTimer || wakeIrq || wakeHost)) |=> (modeStatus == 2'd0 && mainClkEn));

  a_r4_save_pulse: assert property (@(posedge clk) disable iff (!rstN)
    saveStrobe |=> !saveStrobe);

  a_r4_save_clk_gated: assert property (@(posedge clk) disable iff (!rstN)
    saveStrobe |-> !mainClkEn && corePwrEn);

  a_r4_iso_before_off: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(corePwrEn) && modeStatus == 2'd2) |-> coreIsoEn);

  a_r5_restore_powered: assert property (@(posedge clk) disable iff (!rstN)
    restoreStrobe |-> corePwrEn && coreIsoEn && !mainClkEn);

  a_r6_ungate_after_iso: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainClkEn) |-> !coreIsoEn);

  a_r8_off_outputs: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus == 2'd3 |-> !regEn && !corePwrEn && !mainClkEn && !analogPwrEn);

  a_r8_off_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'd3 && !extEnable) |=> modeStatus == 2'd3);

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .wakeTimer(wakeTimer), .wakeIrq(wakeIrq),
  .wakeHost(wakeHost), .extEnable(extEnable), .mainClkEn(mainClkEn),
  .analogPwrEn(analogPwrEn), .corePwrEn(corePwrEn), .coreIsoEn(coreIsoEn),
  .regEn(regEn), .saveStrobe(saveStrobe), .restoreStrobe(restoreStrobe),
  .modeStatus(modeStatus)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;

  localparam int SW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqMode = 2'd0;
  logic wakeTimer = 1'b0, wakeIrq = 1'b0, wakeHost = 1'b0;
  logic extEnable = 1'b0, saveDone = 1'b0, restoreDone = 1'b0;
  logic [SW-1:0] settleCount = '0;
  logic mainClkEn, analogPwrEn, linRegEn, corePwrEn, coreIsoEn, regEn;
  logic saveStrobe, restoreStrobe;
  logic [1:0] modeStatus;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.SETTLE_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .wakeTimer(wakeTimer), .wakeIrq(wakeIrq), .wakeHost(wakeHost),
    .extEnable(extEnable), .saveDone(saveDone), .restoreDone(restoreDone),
    .settleCount(settleCount), .mainClkEn(mainClkEn), .analogPwrEn(analogPwrEn),
    .linRegEn(linRegEn), .corePwrEn(corePwrEn), .coreIsoEn(coreIsoEn),
    .regEn(regEn), .saveStrobe(saveStrobe), .restoreStrobe(restoreStrobe),
    .modeStatus(modeStatus)
  );

  // Enable vector order: clk, analog, linear, core, iso, reg
  function automatic int vec(input bit c, input bit a, input bit l,
                             input bit p, input bit i, input bit r);
    return {26'd0, c, a, l, p, i, r};
  endfunction

  function automatic int outs();
    return vec(mainClkEn, analogPwrEn, linRegEn, corePwrEn, coreIsoEn, regEn);
  endfunction

  localparam int V_ACTIVE = 6'b111101;
  localparam int V_DOZE   = 6'b000101;
  localparam int V_DEEP   = 6'b000011;
  localparam int V_OFF    = 6'b000000;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic pulseReq(input int m);
    @(negedge clk); reqValid = 1'b1; reqMode = 2'(m);
    @(negedge clk); reqValid = 1'b0; reqMode = 2'd0;
  endtask

  task automatic setWake(input int src, input bit v);
    case (src)
      0: wakeTimer = v;
      1: wakeIrq = v;
      default: wakeHost = v;
    endcase
  endtask

  task automatic pulseWake(input int src);
    @(negedge clk); setWake(src, 1'b1);
    @(negedge clk); setWake(src, 1'b0);
  endtask

  task automatic pulseSaveDone();
    @(negedge clk); saveDone = 1'b1;
    @(negedge clk); saveDone = 1'b0;
  endtask

  task automatic enterDeep();
    int waited;
    pulseReq(2);
    chk("R4 status on entry", modeStatus, 2);
    chk("R4 clock gated first", mainClkEn, 0);
    waited = 0;
    while (!saveStrobe && waited < 20) begin @(negedge clk); waited++; end
    chk("R4 save strobe one cycle after gating", waited, 1);
    chk("R4 clock gated during save", mainClkEn, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R4 save strobe single cycle", saveStrobe, 0);
      chk("R4 no isolation before save-done", coreIsoEn, 0);
      chk("R4 core powered during save", corePwrEn, 1);
    end
    pulseSaveDone();
    chk("R4 isolation after save-done", coreIsoEn, 1);
    chk("R4 core still powered while isolating", corePwrEn, 1);
    @(negedge clk);
    chk("R5 deep-sleep resident outputs", outs(), V_DEEP);
    chk("R5 deep-sleep status", modeStatus, 2);
  endtask

  task automatic exitDeep(input int src, input int n);
    int cnt;
    settleCount = SW'(n);
    repeat (2) @(negedge clk);
    chk("R5 stays asleep without wake", outs(), V_DEEP);
    pulseWake(src);
    chk("R5 core powered after wake", corePwrEn, 1);
    chk("R5 isolation held at power-on", coreIsoEn, 1);
    cnt = 0;
    while (!restoreStrobe && cnt < 300) begin @(negedge clk); cnt++; end
    chk("R5 settle distance", cnt, n + 1);
    @(negedge clk);
    chk("R5 restore strobe single cycle", restoreStrobe, 0);
    @(negedge clk);
    chk("R6 isolation held before restore-done", coreIsoEn, 1);
    @(negedge clk); restoreDone = 1'b1;
    @(negedge clk); restoreDone = 1'b0;
    chk("R6 isolation released", coreIsoEn, 0);
    chk("R6 clock still gated at release", mainClkEn, 0);
    @(negedge clk);
    chk("R6 active after exit", outs(), V_ACTIVE);
    chk("R6 status after exit", modeStatus, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset enables", outs(), V_ACTIVE);
    chk("R1 reset strobes", {saveStrobe, restoreStrobe}, 0);
    chk("R1 reset status", modeStatus, 0);

    // R9 request for mode 0 in Active ignored
    pulseReq(0);
    chk("R9 mode 0 request ignored", outs(), V_ACTIVE);
    chk("R9 mode 0 status", modeStatus, 0);

    // R2/R3 Doze and wake from each source
    for (int s = 0; s < 3; s++) begin
      pulseReq(1);
      chk("R2 doze enables", outs(), V_DOZE);
      chk("R2 doze status", modeStatus, 1);
      pulseReq(2);
      chk("R9 request in doze ignored", modeStatus, 1);
      @(negedge clk); extEnable = 1'b1;
      @(negedge clk); extEnable = 1'b0;
      chk("R9 external enable in doze ignored", outs(), V_DOZE);
      pulseWake(s);
      chk("R3 doze wake enables", outs(), V_ACTIVE);
      chk("R3 doze wake status", modeStatus, 0);
    end

    // R4/R5/R6 full deep-sleep cycles, sweep wake source and settle
    for (int s = 0; s < 3; s++) begin
      for (int n = 0; n < 5; n++) begin
        enterDeep();
        pulseReq(3);
        chk("R9 request in deep-sleep ignored", outs(), V_DEEP);
        exitDeep(s, n * 3 + s);
      end
    end

    // R7 aborts at each entry step, each wake source
    for (int s = 0; s < 3; s++) begin
      // step 0: right after clock gating
      pulseReq(2);
      setWake(s, 1'b1);
      @(negedge clk); setWake(s, 1'b0);
      chk("R7 abort after gating", outs(), V_ACTIVE);
      chk("R7 abort after gating status", modeStatus, 0);
      chk("R7 no save after early abort", saveStrobe, 0);
      @(negedge clk);
      chk("R7 no late save strobe", saveStrobe, 0);

      // step 1: while waiting for save-done
      pulseReq(2);
      @(negedge clk);
      setWake(s, 1'b1);
      @(negedge clk); setWake(s, 1'b0);
      repeat (2) @(negedge clk);
      chk("R7 save completes before abort", modeStatus, 2);
      pulseSaveDone();
      chk("R7 abort on save-done", outs(), V_ACTIVE);
      chk("R7 abort on save-done status", modeStatus, 0);

      // step 2: from the isolated state
      pulseReq(2);
      @(negedge clk);
      pulseSaveDone();
      chk("R7 isolated before abort", outs(), 6'b000111);
      setWake(s, 1'b1);
      @(negedge clk); setWake(s, 1'b0);
      chk("R7 abort from isolation", outs(), V_ACTIVE);
      chk("R7 abort from isolation status", modeStatus, 0);
    end

    // R8 power-down
    pulseReq(3);
    chk("R8 power-down outputs", outs(), V_OFF);
    chk("R8 power-down status", modeStatus, 3);
    for (int s = 0; s < 3; s++) begin
      pulseWake(s);
      chk("R8 wake ignored in power-down", outs(), V_OFF);
      chk("R8 wake ignored status", modeStatus, 3);
    end
    pulseReq(1);
    chk("R9 request in power-down ignored", modeStatus, 3);
    @(negedge clk); extEnable = 1'b1;
    @(negedge clk); extEnable = 1'b0;
    chk("R8 external enable leaves power-down", outs(), V_ACTIVE);
    chk("R8 status after external enable", modeStatus, 0);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule